// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

This block picks which of six interrupt sources an 8-bit controller core should service next. Software programs an enable register and two priority-bit registers over a small write-only register bus. Each source gets one of four levels from its pair of priority bits. The block keeps a record of the levels whose handlers are running. A new request goes to the core only when its level is above every level already in service. That gives preemption and nesting, and a preempted handler carries on once the higher one returns.

The six sources are two external inputs, two timer overflows, a serial port (receive or transmit) and a third timer (overflow or capture). Each has a request flag inside the block. The external inputs can be level- or edge-sensitive. The block clears the flag itself when it vectors to an edge-sensitive external input or to either of the first two timers. The serial and third-timer flags belong to the peripherals and stay set until software clears them there. The core sees a request line with a vector address that holds still until the core acknowledges. A return pulse tells the block that the innermost handler has finished.

Top module: `nestIrqCtl`

## Requirements
- R1: After reset, irqReq is 0, irqVec is 00H, no level is in service, and the enable and both priority registers are 0.
- R2: A write to address A8H loads the enable register, B8H loads the low priority bits and B7H loads the high priority bits. In each register, bit 0 is external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial and bit 5 timer 2. Enable bit 7 is the global enable. A write to any other address changes nothing.
- R3: While global enable bit 7 is 0, no request is raised, whatever the per-source enable bits hold.
- R4: A source's level is {high bit, low bit}, from 0 (lowest) to 3 (highest). Among eligible sources, the one with the highest level wins.
- R5: Among eligible sources of the same level, the winner is the first in this order: external 0, timer 0, external 1, timer 1, serial, timer 2.
- R6: A source is eligible only if its level is greater than every level currently in service. An acknowledge marks the acknowledged level as in service.
- R7: The vector is 03H + 8 × source index (external 0 is 03H, timer 2 is 2BH).
- R8: A pulse on irqRet removes only the highest level in service, so a preempted lower level stays in service.
- R9: Acknowledging an edge-sensitive external source or timer 0/1 clears that flag. A level-sensitive external source, the serial port and timer 2 keep requesting after their handler returns, for as long as their inputs stay high.
- R10: Once irqReq is high, it stays high with irqVec unchanged until irqAck. It is low in the cycle after the acknowledge.
- R11: A register write in the same cycle as an acknowledge does not change the level recorded as in service for that acknowledge.
- R12: An edge-sensitive external source latches a flag on a 0-to-1 change of its pin. A level-sensitive one requests while its pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| extPin | input | 2 | External interrupt inputs (bit 0 external 0, bit 1 external 1) |
| extEdge | input | 2 | 1 selects edge sensitivity for the matching external input |
| tmrOvf | input | 2 | One-cycle overflow pulses of timer 0 and timer 1 |
| serRx | input | 1 | Serial receive flag level |
| serTx | input | 1 | Serial transmit flag level |
| t2Ovf | input | 1 | Timer 2 overflow flag level |
| t2Cap | input | 1 | Timer 2 external flag level |
| irqAck | input | 1 | Core accepts the presented vector |
| irqRet | input | 1 | Return from the innermost handler |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 8 | Vector address of the request |

## Verification
The bench puts a pending request of one level into service and then checks that requests of equal or lower level stay blocked while higher ones still preempt. A design that compared levels with "greater or equal" would let a handler nest inside one of the same level. A nested return must remove only the top level; clearing the whole in-service record would let low-level sources cut into an unfinished handler. The bench also raises a higher source while a lower request is waiting, and writes the priority bits in the same cycle as an acknowledge. A design that re-arbitrated a pending request would change the vector under the core, and one that read the new bits would record the wrong level. Finally it holds an edge-sensitive pin high through a handler. Without the hardware clear, that source would request again after the return.

// File: rtl/nestIrqPkg.sv
package nestIrqPkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = 2;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [1:0] {KIND_EXT, KIND_TMR, KIND_PERIPH} srcKind_e;

  // source order is also the polling order
  function automatic srcKind_e kindOf(input int idx);
    if (idx == 0 || idx == 2) return KIND_EXT;
    if (idx == 1 || idx == 3) return KIND_TMR;
    return KIND_PERIPH;
  endfunction

  typedef struct packed {
    logic capture;  // latch arbitration winner into the held slot
    logic take;     // core acknowledged the held request
  } ctlStrobe_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import nestIrqPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int VEC_W      = 8,
  parameter int EN_ADDR    = 'hA8,
  parameter int PLO_ADDR   = 'hB8,
  parameter int PHI_ADDR   = 'hB7,
  parameter int VEC_BASE   = 'h03,
  parameter int VEC_STRIDE = 8,
  parameter int GLOBAL_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_LVL-1:0] inService,
  input  ctlStrobe_t         strobe,
  output logic               winValid,
  output logic [VEC_W-1:0]   heldVec,
  output logic [LVL_W-1:0]   heldLvl,
  output logic               eaBit
);
  logic [NUM_SRC-1:0] enBits, loBits, hiBits;
  logic [NUM_SRC-1:0] flags, rawPrev, eligible;
  logic [SRC_W-1:0]   heldSrc, winIdx;
  logic [LVL_W-1:0]   winLvl;
  logic [LVL_W:0]     ceilLvl;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];

  // register bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBits <= '0;
      loBits <= '0;
      hiBits <= '0;
      eaBit  <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(EN_ADDR)) begin
        enBits <= regWrData[NUM_SRC-1:0];
        eaBit  <= regWrData[GLOBAL_BIT];
      end
      if (regAddr == ADDR_W'(PLO_ADDR)) loBits <= regWrData[NUM_SRC-1:0];
      if (regAddr == ADDR_W'(PHI_ADDR)) hiBits <= regWrData[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rawPrev <= '0;
    else       rawPrev <= srcRaw;
  end

  // per-source flag, clear policy chosen by source kind
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hwClr;
    assign hwClr     = strobe.take && (heldSrc == SRC_W'(i));
    assign srcLvl[i] = {hiBits[i], loBits[i]};
    if (kindOf(i) == KIND_EXT) begin : g_ext
      always_ff @(posedge clk) begin
        if (!rstN)          flags[i] <= 1'b0;
        else if (edgeSel[i]) flags[i] <= (flags[i] & ~hwClr) | (srcRaw[i] & ~rawPrev[i]);
        else                flags[i] <= srcRaw[i];
      end
    end else if (kindOf(i) == KIND_TMR) begin : g_tmr
      always_ff @(posedge clk) begin
        if (!rstN) flags[i] <= 1'b0;
        else       flags[i] <= (flags[i] & ~hwClr) | srcRaw[i];
      end
      p_tmr_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
        (hwClr && !srcRaw[i]) |=> !flags[i]);
    end else begin : g_per
      always_ff @(posedge clk) begin
        if (!rstN) flags[i] <= 1'b0;
        else       flags[i] <= srcRaw[i];
      end
    end
  end

  // ceiling: 0 when idle, else highest in-service level + 1
  always_comb begin
    ceilLvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) ceilLvl = (LVL_W+1)'(l + 1);
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      eligible[i] = flags[i] && enBits[i] && eaBit && ({1'b0, srcLvl[i]} >= ceilLvl);
  end

  // scan from last to first so ties fall to the earlier source
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLvl   = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (eligible[i] && (!winValid || srcLvl[i] >= winLvl)) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
        winLvl   = srcLvl[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVec <= '0;
      heldLvl <= '0;
      heldSrc <= '0;
    end else if (strobe.capture) begin
      heldVec <= VEC_W'(VEC_BASE + VEC_STRIDE * int'(winIdx));
      heldLvl <= winLvl;
      heldSrc <= winIdx;
    end
  end

  p_held_ok_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (inService >> heldLvl) == '0 || $past(strobe.take) || $fell(inService[heldLvl]));
endmodule

// File: rtl/irqControl.sv
module irqControl
  import nestIrqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic [LVL_W-1:0]   heldLvl,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               irqReq,
  output logic [NUM_LVL-1:0] inService,
  output ctlStrobe_t         strobe
);
  logic [NUM_LVL-1:0] topMask, svcNext;

  assign strobe.capture = !irqReq && winValid;
  assign strobe.take    = irqReq && irqAck;

  always_ff @(posedge clk) begin
    if (!rstN)             irqReq <= 1'b0;
    else if (strobe.take)  irqReq <= 1'b0;
    else if (strobe.capture) irqReq <= 1'b1;
  end

  always_comb begin
    topMask = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) topMask = NUM_LVL'(1) << l;
  end

  always_comb begin
    svcNext = inService;
    if (irqRet)      svcNext = svcNext & ~topMask;
    if (strobe.take) svcNext = svcNext | (NUM_LVL'(1) << heldLvl);
  end

  always_ff @(posedge clk) begin
    if (!rstN) inService <= '0;
    else       inService <= svcNext;
  end

  p_svc_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> inService[$past(heldLvl)]);
  p_ret_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqRet && !strobe.take && inService != '0) |=>
      $countones(inService) == $countones($past(inService)) - 1);
  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !irqReq);
endmodule

// File: rtl/nestIrqCtl.sv
module nestIrqCtl
  import nestIrqPkg::*;
#(
  parameter int EN_ADDR  = 'hA8,
  parameter int PLO_ADDR = 'hB8,
  parameter int PHI_ADDR = 'hB7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic [1:0] extPin,
  input  logic [1:0] extEdge,
  input  logic [1:0] tmrOvf,
  input  logic       serRx,
  input  logic       serTx,
  input  logic       t2Ovf,
  input  logic       t2Cap,
  input  logic       irqAck,
  input  logic       irqRet,
  output logic       irqReq,
  output logic [7:0] irqVec
);
  logic [NUM_SRC-1:0] srcRaw, edgeSel;
  logic [NUM_LVL-1:0] inService;
  logic [LVL_W-1:0]   heldLvl;
  logic               winValid, eaBit;
  ctlStrobe_t         strobe;

  assign srcRaw  = {t2Ovf | t2Cap, serRx | serTx, tmrOvf[1], extPin[1], tmrOvf[0], extPin[0]};
  assign edgeSel = {3'b000, extEdge[1], 1'b0, extEdge[0]};

  irqDatapath #(
    .EN_ADDR (EN_ADDR),
    .PLO_ADDR(PLO_ADDR),
    .PHI_ADDR(PHI_ADDR)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .srcRaw   (srcRaw),
    .edgeSel  (edgeSel),
    .inService(inService),
    .strobe   (strobe),
    .winValid (winValid),
    .heldVec  (irqVec),
    .heldLvl  (heldLvl),
    .eaBit    (eaBit)
  );

  irqControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .heldLvl  (heldLvl),
    .irqAck   (irqAck),
    .irqRet   (irqRet),
    .irqReq   (irqReq),
    .inService(inService),
    .strobe   (strobe)
  );

  p_ea_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(eaBit));
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq && $stable(irqVec));
endmodule

// File: tb/nestIrqCtl_test.sv
module nestIrqCtl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic [1:0] extPin = '0, extEdge = '0, tmrOvf = '0;
  logic       serRx = 1'b0, serTx = 1'b0, t2Ovf = 1'b0, t2Cap = 1'b0;
  logic       irqAck = 1'b0, irqRet = 1'b0;
  logic       irqReq;
  logic [7:0] irqVec;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  nestIrqCtl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .extPin(extPin), .extEdge(extEdge), .tmrOvf(tmrOvf), .serRx(serRx), .serTx(serTx),
    .t2Ovf(t2Ovf), .t2Cap(t2Cap), .irqAck(irqAck), .irqRet(irqRet),
    .irqReq(irqReq), .irqVec(irqVec)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    extPin = '0; extEdge = '0; tmrOvf = '0;
    serRx = 0; serTx = 0; t2Ovf = 0; t2Cap = 0; irqAck = 0; irqRet = 0; regWrEn = 0;
    rstN = 1'b0; tick(2); rstN = 1'b1;
  endtask

  task automatic ack();
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
  endtask

  task automatic ret();
    irqRet = 1'b1; tick(1); irqRet = 1'b0;
  endtask

  task automatic pulseTmr(input int t);
    tmrOvf[t] = 1'b1; tick(1); tmrOvf[t] = 1'b0;
  endtask

  // expected winner: -1 when nothing is eligible
  function automatic int expWin(input logic [5:0] flg, input logic [7:0] en,
                                input logic [5:0] lo, input logic [5:0] hi,
                                input logic [3:0] svc);
    int best = -1, bestLvl = -1, ceilv = 0;
    for (int l = 0; l < 4; l++) if (svc[l]) ceilv = l + 1;
    if (!en[7]) return -1;
    for (int i = 0; i < 6; i++) begin
      int lv = {hi[i], lo[i]};
      if (flg[i] && en[i] && lv >= ceilv && lv > bestLvl) begin
        best = i; bestLvl = lv;
      end
    end
    return best;
  endfunction

  function automatic int vecOf(input int i);
    return 3 + 8 * i;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset();
    // R1 reset state
    chk("R1 req after reset", irqReq, 0);
    chk("R1 vec after reset", irqVec, 0);
    extPin[0] = 1; tick(3);
    chk("R1 enable cleared", irqReq, 0);
    extPin[0] = 0;

    // R2 wrong address ignored
    wr(8'hA9, 8'h81); extPin[0] = 1; tick(3);
    chk("R2 stray address", irqReq, 0);
    // R3 global enable off
    wr(8'hA8, 8'h3F); tick(2);
    chk("R3 EA off blocks", irqReq, 0);
    wr(8'hA8, 8'hBF); tick(2);
    chk("R2 R3 enable taken", irqReq, 1);
    chk("R7 ext0 vector", irqVec, 8'h03);
    doReset();

    // R5 polling among serial and timer2 at equal level, R7 vector
    wr(8'hA8, 8'hB0); wr(8'hB8, 8'h30);
    serTx = 1; t2Cap = 1; tick(3);
    chk("R5 serial before timer2", irqVec, 8'h23);
    ack();
    chk("R10 req low after ack", irqReq, 0);
    tick(2);
    chk("R6 same level blocked", irqReq, 0);
    ret(); tick(2);
    chk("R9 serial flag persists", irqVec, 8'h23);
    chk("R9 serial req again", irqReq, 1);
    doReset();

    // R10 vector held while higher source appears, then preemption, R8 R9
    wr(8'hA8, 8'h89); wr(8'hB7, 8'h08); wr(8'hB8, 8'h08);
    extPin[0] = 1; tick(3);
    chk("R12 level ext0", irqVec, 8'h03);
    pulseTmr(1); tick(3);
    chk("R10 vec held", irqVec, 8'h03);
    chk("R10 req held", irqReq, 1);
    ack(); tick(2);
    chk("R4 timer1 preempts", irqVec, 8'h1B);
    chk("R6 higher level taken", irqReq, 1);
    ack(); tick(2);
    chk("R6 nothing above 3", irqReq, 0);
    ret(); tick(3);
    chk("R8 level 0 still in service", irqReq, 0);
    ret(); tick(2);
    chk("R9 level ext re-requests", irqReq, 1);
    chk("R9 timer flag cleared", irqVec, 8'h03);
    doReset();

    // R12 R9 edge-sensitive ext0
    wr(8'hA8, 8'h81); extEdge[0] = 1;
    extPin[0] = 1; tick(3);
    chk("R12 edge latched", irqReq, 1);
    ack(); tick(1); ret(); tick(3);
    chk("R9 edge flag cleared", irqReq, 0);
    extPin[0] = 0; tick(1); extPin[0] = 1; tick(1); extPin[0] = 0; tick(2);
    chk("R12 second edge", irqReq, 1);
    doReset();

    // R11 write in ack cycle uses old level
    wr(8'hA8, 8'h86); wr(8'hB8, 8'h04);
    pulseTmr(0); tick(2);
    chk("R11 timer0 pending", irqVec, 8'h0B);
    irqAck = 1; regWrEn = 1; regAddr = 8'hB7; regWrData = 8'h02;
    tick(1);
    irqAck = 0; regWrEn = 0;
    extPin[1] = 1; tick(3);
    chk("R11 old level recorded", irqReq, 1);
    chk("R11 ext1 vector", irqVec, 8'h13);
    doReset();

    // randomized arbitration and nesting
    for (int it = 0; it < 40; it++) begin
      logic [7:0] en; logic [5:0] lo, hi, msk; logic [3:0] svc;
      int w, w2;
      doReset();
      en = 8'($urandom()) & 8'hBF;
      if ($urandom() % 5 != 0) en[7] = 1;
      lo = 6'($urandom()); hi = 6'($urandom()); msk = 6'($urandom());
      wr(8'hA8, en); wr(8'hB8, {2'b00, lo}); wr(8'hB7, {2'b00, hi});
      extPin = {msk[2], msk[0]}; serRx = msk[4]; t2Ovf = msk[5];
      tmrOvf = {msk[3], msk[1]};
      tick(1); tmrOvf = '0; tick(2);
      svc = '0;
      w = expWin(msk, en, lo, hi, svc);
      chk("R4 R5 random req", irqReq, (w >= 0) ? 1 : 0);
      if (w >= 0) begin
        chk("R4 R5 R7 random vec", irqVec, vecOf(w));
        ack();
        svc[{hi[w], lo[w]}] = 1'b1;
        if (w == 1 || w == 3) msk[w] = 1'b0;
        tick(2);
        w2 = expWin(msk, en, lo, hi, svc);
        chk("R6 random nest req", irqReq, (w2 >= 0) ? 1 : 0);
        if (w2 >= 0) chk("R6 random nest vec", irqVec, vecOf(w2));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule